// File: doc/BRIEF.md
# Interrupt and Sleep-Wake Controller

This block sits next to a small 8-bit processor core. It decides when the core must fetch its next instruction from the interrupt vector, and when a sleeping core starts running again. Request lines from two groups of sources are latched on their rising edges into two sticky flag registers. Each flag register has a matching mask register. Software reads both kinds of register through plain ports. It clears flags by writing zeros, and it writes the masks directly.

A global enable is turned on by the enable-interrupt and return-from-interrupt instructions. It is turned off by the disable-interrupt instruction and when a vector is taken. The core reports each retired instruction with a boundary strobe, the decoded instruction strobes and the address of the following instruction. A pending unmasked flag is acted on only at such a boundary.

Executing the sleep instruction stops the oscillator and clears the watchdog. An unmasked flag ends the sleep. If the global enable is on, the controller also vectors, and it saves the address after the sleep instruction as the return point. A watchdog timeout also ends the sleep, but it resumes execution without vectoring.

Top module: `irq_wake_ctrl`

## Requirements
- R1: A request bit sets its flag only on a low-to-high transition: the flag reads 1 after the clock edge at which the request is first sampled high. A request held high does not set the flag again after software has cleared it.
- R2: Hardware never clears a flag. A write with `sw_wr_flag[g]` high (g=0 is group A, g=1 is group B) ANDs that group's flags with `sw_wdata`: a 0 bit clears the flag and a 1 bit leaves it unchanged. If a rising request arrives in the same cycle as a clear of that flag, the flag ends up set.
- R3: Mask registers reset to 0 and take `sw_wdata` when `sw_wr_mask[g]` is high. A set flag whose mask bit is 0 neither causes a vector nor wakes the core.
- R4: The global enable `gie` resets to 0. At an instruction boundary it is set by enable-interrupt and cleared by disable-interrupt.
- R5: At a boundary (`ins_done` high while running) with `gie` high and any flag set whose mask bit is 1, `vec_req` pulses for one cycle in the next cycle. In that same cycle `ret_addr` equals the `pc_next` that was presented and `gie` reads 0. `vec_addr` is always 0x008.
- R6: A pending interrupt never produces `vec_req` in a cycle that follows a cycle without an instruction boundary.
- R7: Return-from-interrupt sets `gie`. A flag that was left set then vectors again at the next boundary.
- R8: When sleep retires, `osc_run` reads 0 in the next cycle and `wdt_clr` pulses for that one cycle. Flags and masks are kept unchanged.
- R9: While asleep, an unmasked set flag raises `osc_run` and pulses `wake` one cycle later. If `gie` is high, `vec_req` pulses in the same cycle and `ret_addr` holds the `pc_next` that was presented with the sleep instruction.
- R10: While asleep with no unmasked flag set, a `wdt_timeout` pulse raises `osc_run` and pulses `wake` in the next cycle. There is no `vec_req`, and `gie` is left unchanged.
- R11: After reset all flags and masks are 0, `osc_run` is 1, and `vec_req`, `wake` and `wdt_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_a | input | FLAG_W | Group A request lines |
| req_b | input | FLAG_W | Group B request lines |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| ins_done | input | 1 | Instruction boundary strobe |
| op_eni | input | 1 | Enable-interrupt instruction retiring |
| op_disi | input | 1 | Disable-interrupt instruction retiring |
| op_sleep | input | 1 | Sleep instruction retiring |
| op_reti | input | 1 | Return-from-interrupt retiring |
| pc_next | input | PC_W | Address of the instruction after the retiring one |
| sw_wr_flag | input | 2 | Flag clear-write strobe per group |
| sw_wr_mask | input | 2 | Mask write strobe per group |
| sw_wdata | input | FLAG_W | Software write data |
| flag_a | output | FLAG_W | Group A flags |
| flag_b | output | FLAG_W | Group B flags |
| mask_a | output | FLAG_W | Group A masks |
| mask_b | output | FLAG_W | Group B masks |
| gie | output | 1 | Global interrupt enable |
| vec_req | output | 1 | Fetch-from-vector pulse |
| vec_addr | output | PC_W | Vector address (0x008) |
| ret_addr | output | PC_W | Saved return address |
| osc_run | output | 1 | Oscillator run (1) / stop (0) |
| wake | output | 1 | Wake-up event pulse |
| wdt_clr | output | 1 | Watchdog clear pulse |

## Verification
The bench clears a flag in the same cycle as a new rising request. A design that let the clear win would lose that interrupt. It holds a request high across a software clear: edge latching that had decayed into level latching would set the flag again at once. It returns from an interrupt without clearing the flag, to check that the vector is taken again, and it holds a pending interrupt through cycles with no boundary, where a premature vector would cut an instruction short. During sleep it checks three cases: a masked flag must not wake the core, a watchdog wake must not vector, and an interrupt wake must return to the address after the sleep rather than the address of the last normal boundary.

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int FLAG_W   = 8,
  parameter int PC_W     = 11,
  parameter int VEC_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] req_a,
  input  logic [FLAG_W-1:0] req_b,
  input  logic              wdt_timeout,
  input  logic              ins_done,
  input  logic              op_eni,
  input  logic              op_disi,
  input  logic              op_sleep,
  input  logic              op_reti,
  input  logic [PC_W-1:0]   pc_next,
  input  logic [1:0]        sw_wr_flag,
  input  logic [1:0]        sw_wr_mask,
  input  logic [FLAG_W-1:0] sw_wdata,
  output logic [FLAG_W-1:0] flag_a,
  output logic [FLAG_W-1:0] flag_b,
  output logic [FLAG_W-1:0] mask_a,
  output logic [FLAG_W-1:0] mask_b,
  output logic              gie,
  output logic              vec_req,
  output logic [PC_W-1:0]   vec_addr,
  output logic [PC_W-1:0]   ret_addr,
  output logic              osc_run,
  output logic              wake,
  output logic              wdt_clr
);
  localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);

  logic [1:0][FLAG_W-1:0] req_v, req_q, flg, msk;
  logic [PC_W-1:0] resume_pc;
  logic pend, bound, sleep_go, take_run, take_slp, wake_go;

  assign req_v    = {req_b, req_a};
  assign pend     = |(flg[0] & msk[0]) | |(flg[1] & msk[1]);
  assign bound    = osc_run & ins_done;
  assign sleep_go = bound & op_sleep;
  assign take_run = bound & gie & pend & ~op_disi & ~op_sleep;
  assign wake_go  = ~osc_run & (pend | wdt_timeout);
  assign take_slp = ~osc_run & pend & gie;

  assign flag_a   = flg[0];
  assign flag_b   = flg[1];
  assign mask_a   = msk[0];
  assign mask_b   = msk[1];
  assign vec_addr = VEC_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      flg   <= '0;
      msk   <= '0;
    end else begin
      req_q <= req_v;
      for (int g = 0; g < 2; g++) begin
        flg[g] <= (sw_wr_flag[g] ? (flg[g] & sw_wdata) : flg[g]) | (req_v[g] & ~req_q[g]);
        if (sw_wr_mask[g]) msk[g] <= sw_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie       <= 1'b0;
      vec_req   <= 1'b0;
      ret_addr  <= '0;
      resume_pc <= '0;
      osc_run   <= 1'b1;
      wake      <= 1'b0;
      wdt_clr   <= 1'b0;
    end else begin
      vec_req <= take_run | take_slp;
      wake    <= wake_go;
      wdt_clr <= sleep_go;
      if (sleep_go) begin
        osc_run   <= 1'b0;
        resume_pc <= pc_next;
      end else if (wake_go) begin
        osc_run <= 1'b1;
      end
      if (take_run)      ret_addr <= pc_next;
      else if (take_slp) ret_addr <= resume_pc;
      if (take_run | take_slp) gie <= 1'b0;
      else if (bound) begin
        if (op_eni)       gie <= 1'b1;
        else if (op_disi) gie <= 1'b0;
        else if (op_reti) gie <= 1'b1;
      end
    end
  end

  AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_flag[0] |=> ((flag_a & $past(flag_a)) == $past(flag_a))); // R2
  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_flag[1] |=> ((flag_b & $past(flag_b)) == $past(flag_b))); // R2
  AST_VEC_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (!gie && $past(gie))); // R5
  AST_VEC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && !ins_done) |=> !vec_req); // R6
  AST_SLEEP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && ins_done && op_sleep) |=> (!osc_run && wdt_clr)); // R8
  AST_WAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (osc_run && $past(!osc_run))); // R9
  AST_WDT_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && wdt_timeout && !pend) |=> (wake && !vec_req)); // R10
endmodule

// File: tb/sim_irq_wake_ctrl.sv
module sim_irq_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int PW = 11;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] req_a = '0, req_b = '0, sw_wdata = '0;
  logic wdt_timeout = 0, ins_done = 0, op_eni = 0, op_disi = 0, op_sleep = 0, op_reti = 0;
  logic [PW-1:0] pc_next = '0;
  logic [1:0] sw_wr_flag = '0, sw_wr_mask = '0;
  logic [W-1:0] flag_a, flag_b, mask_a, mask_b;
  logic gie, vec_req, osc_run, wake, wdt_clr;
  logic [PW-1:0] vec_addr, ret_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_wake_ctrl #(.FLAG_W(W), .PC_W(PW), .VEC_ADDR(8)) u0 (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic retire(logic eni, logic disi, logic slp, logic reti, logic [PW-1:0] pc);
    ins_done = 1; op_eni = eni; op_disi = disi; op_sleep = slp; op_reti = reti; pc_next = pc;
    tick;
    ins_done = 0; op_eni = 0; op_disi = 0; op_sleep = 0; op_reti = 0;
  endtask

  task automatic wflag(int g, logic [W-1:0] d);
    sw_wr_flag[g] = 1; sw_wdata = d; tick; sw_wr_flag = '0;
  endtask

  task automatic wmask(int g, logic [W-1:0] d);
    sw_wr_mask[g] = 1; sw_wdata = d; tick; sw_wr_mask = '0;
  endtask

  task automatic t_reset;
    chk("R11 flag_a", flag_a, 0); chk("R11 flag_b", flag_b, 0);
    chk("R11 mask_a", mask_a, 0); chk("R11 mask_b", mask_b, 0);
    chk("R4 gie reset", gie, 0); chk("R11 osc_run", osc_run, 1);
    chk("R11 vec_req", vec_req, 0); chk("R11 wake", wake, 0); chk("R11 wdt_clr", wdt_clr, 0);
  endtask

  task automatic t_edge_latch;
    req_a[3] = 1; tick;
    chk("R1 rise sets flag", flag_a, 8'h08);
    wflag(0, 8'h00);
    chk("R1 cleared while held", flag_a, 0);
    tick; tick;
    chk("R1 held level no reset", flag_a, 0);
    req_a[3] = 0; tick;
  endtask

  task automatic t_clear_race;
    req_a[1] = 1; tick; req_a[1] = 0;
    chk("R2 flag set", flag_a, 8'h02);
    req_a[5] = 1; sw_wr_flag[0] = 1; sw_wdata = 8'h00; tick;
    sw_wr_flag = '0; req_a[5] = 0;
    chk("R2 request beats clear", flag_a, 8'h20);
    req_a[1] = 1; tick; req_a[1] = 0;
    wflag(0, 8'hFF);
    chk("R2 write ones keeps", flag_a, 8'h22);
    wflag(0, 8'hDF);
    chk("R2 write zero clears bit", flag_a, 8'h02);
    wflag(0, 8'h00);
  endtask

  task automatic t_mask_gie;
    wmask(1, 8'h04);
    chk("R3 mask write", mask_b, 8'h04);
    retire(1, 0, 0, 0, 11'h010);
    chk("R4 eni sets gie", gie, 1);
    retire(0, 1, 0, 0, 11'h011);
    chk("R4 disi clears gie", gie, 0);
    retire(1, 0, 0, 0, 11'h012);
    req_b[0] = 1; tick; req_b[0] = 0;
    retire(0, 0, 0, 0, 11'h013);
    chk("R3 masked flag no vector", vec_req, 0);
    chk("R3 masked flag kept", flag_b, 8'h01);
    wflag(1, 8'h00);
  endtask

  task automatic t_vector;
    req_b[2] = 1; tick; req_b[2] = 0;
    retire(0, 0, 0, 0, 11'h123);
    chk("R5 vec_req", vec_req, 1);
    chk("R5 ret_addr", ret_addr, 11'h123);
    chk("R5 vec_addr", vec_addr, 11'h008);
    chk("R5 gie cleared", gie, 0);
    tick;
    chk("R5 single pulse", vec_req, 0);
  endtask

  task automatic t_reti_retrigger;
    retire(0, 0, 0, 1, 11'h200);
    chk("R7 reti sets gie", gie, 1);
    chk("R7 no vector during reti", vec_req, 0);
    retire(0, 0, 0, 0, 11'h124);
    chk("R7 left flag retriggers", vec_req, 1);
    chk("R7 ret_addr", ret_addr, 11'h124);
    wflag(1, 8'h00);
    retire(0, 0, 0, 1, 11'h201);
    retire(0, 0, 0, 0, 11'h202);
    chk("R7 cleared flag no vector", vec_req, 0);
  endtask

  task automatic t_boundary;
    req_b[2] = 1; tick; req_b[2] = 0;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk("R6 no vector mid instruction", vec_req, 0);
    end
    retire(0, 0, 0, 0, 11'h300);
    chk("R6 vector at boundary", vec_req, 1);
    wflag(1, 8'h00);
    retire(0, 0, 0, 1, 11'h301);
  endtask

  task automatic t_sleep_irq;
    retire(0, 0, 1, 0, 11'h050);
    chk("R8 osc stopped", osc_run, 0);
    chk("R8 wdt_clr pulse", wdt_clr, 1);
    chk("R8 mask kept", mask_b, 8'h04);
    tick;
    chk("R8 wdt_clr one cycle", wdt_clr, 0);
    chk("R8 still asleep", osc_run, 0);
    retire(0, 0, 0, 0, 11'h3FF);
    chk("R8 boundary ignored asleep", vec_req, 0);
    req_b[2] = 1; tick; req_b[2] = 0;
    chk("R9 asleep until seen", osc_run, 0);
    tick;
    chk("R9 wake pulse", wake, 1);
    chk("R9 osc restarted", osc_run, 1);
    chk("R9 vector on wake", vec_req, 1);
    chk("R9 resume after sleep", ret_addr, 11'h050);
    tick;
    chk("R9 wake one cycle", wake, 0);
    wflag(1, 8'h00);
    retire(0, 0, 0, 1, 11'h051);
  endtask

  task automatic t_sleep_wdt;
    retire(0, 0, 1, 0, 11'h060);
    req_a[6] = 1; tick; req_a[6] = 0;
    tick; tick;
    chk("R3 masked flag no wake", osc_run, 0);
    chk("R3 masked no wake pulse", wake, 0);
    chk("R8 flag kept asleep", flag_a, 8'h40);
    wdt_timeout = 1; tick; wdt_timeout = 0;
    chk("R10 wdt wake", wake, 1);
    chk("R10 osc restarted", osc_run, 1);
    chk("R10 no vector", vec_req, 0);
    chk("R10 gie unchanged", gie, 1);
    wflag(0, 8'h00);
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    t_reset;
    t_edge_latch;
    t_clear_race;
    t_mask_gie;
    t_vector;
    t_reti_retrigger;
    t_boundary;
    t_sleep_irq;
    t_sleep_wdt;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule